// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch goes taken or not-taken, and learns from the real result of each branch. On each cycle it can take one resolved branch event, made of the instruction address and the actual direction. It builds a table index from two fields. The recent global taken/not-taken history sits in the upper field. The instruction address, after its guaranteed-zero alignment bits are dropped, gives the lower field. The index picks one 2-bit saturating counter. The upper bit of that counter is the guess.

The guess is compared with the actual outcome. One cycle after the event, the result comes out as a registered mispredict flag. In the same cycle as the event, the counter and the history register are trained. Further events then see the new state: each one reads the state left by the event before it, even on consecutive cycles.

Parameters set the history width, the address-field width and the alignment shift. A performance model can feed its branch stream in and count the mispredict flags it gets back.

Top module: `corr_dir_pred`

## Requirements
- R1: After the active-low reset rst_ni is released, mispredict_valid_o and mispredict_o are 0, the history register is 0 and every counter is 0 (strongly not-taken). The first event after reset therefore predicts not-taken on any address, whatever the history was before the reset.
- R2: The counter index is {history[HIST_BITS-1:0], addr_i[LO_ZERO_BITS+PC_BITS-1:LO_ZERO_BITS]}. The history field is in the upper bits. Address bits below LO_ZERO_BITS and above the field do not select a different counter. With the defaults (LO_ZERO_BITS=2, PC_BITS=5), addresses 0x04, 0x07 and 0x84 share a counter.
- R3: The predicted direction is taken when the indexed counter holds 2 or 3, and not-taken when it holds 0 or 1.
- R4: A taken event increments the indexed counter and stops at 3. A not-taken event decrements it and stops at 0.
- R5: Each event shifts the history register left by one bit, and the actual outcome enters at bit 0 (1 = taken).
- R6: mispredict_valid_o is 1 exactly one cycle after a cycle with valid_i=1. At that point mispredict_o is 1 when the predicted direction differs from taken_i. mispredict_o is 0 whenever mispredict_valid_o is 0.
- R7: Events on consecutive cycles that hit the same counter see the value left by the previous event.
- R8: Cycles with valid_i=0 change no counter and no history bit, whatever addr_i and taken_i carry.
- R9: The prediction for an event uses the counter and history values from before that event updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A resolved branch event is present |
| addr_i | input | ADDR_W | Instruction address of the branch |
| taken_i | input | 1 | Actual outcome, 1 = taken |
| mispredict_valid_o | output | 1 | Result of the previous cycle's event is present |
| mispredict_o | output | 1 | The guess for that event was wrong |

## Verification
The stimulus drives a streak of taken branches until the history saturates to all ones. It then trains one counter up to its ceiling and keeps going. A counter that wrapped past 3 would flip its guess to not-taken and flag a mispredict where none is due.

A run of not-taken events at an empty counter, followed by a taken event, exposes a counter that wraps below 0. Such a counter would guess taken and stay silent.

Aliased addresses (bits above the field set, or bits below the alignment shift set) must hit the trained counter. Picking the wrong address bits would land on a fresh counter and report a false mispredict. Idle cycles with junk on taken_i, and a reset in the middle of a run, are checked through the next event's flag: a history that moved during idle, or that survived the reset, changes which counter answers.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t CTR_MIN = 2'd0;

  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/cdp_index.sv
module cdp_index #(
  parameter int ADDR_W       = 32,
  parameter int HIST_BITS    = 5,
  parameter int PC_BITS      = 5,
  parameter int LO_ZERO_BITS = 2,
  localparam int IDX_W       = HIST_BITS + PC_BITS
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [HIST_BITS-1:0] hist_i,
  output logic [IDX_W-1:0]     idx_o
);
  logic unused_addr;

  // history above, aligned address field below
  assign idx_o       = {hist_i, addr_i[LO_ZERO_BITS +: PC_BITS]};
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/cdp_history.sv
module cdp_history #(
  parameter int HIST_BITS = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [HIST_BITS-1:0] hist_o
);
  logic [HIST_BITS-1:0] hist_q;

  generate
    if (HIST_BITS == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= bit_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HIST_BITS-2:0], bit_i};
      end
    end
  endgenerate

  assign hist_o = hist_q;
endmodule

// File: rtl/cdp_ctr_table.sv
module cdp_ctr_table
  import cdp_pkg::*;
#(
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             upd_i,
  input  logic             taken_i,
  output ctr_t             cnt_o
);
  ctr_t cnt_q [DEPTH];

  // flop storage: reset clears all, next event reads the written value
  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q[g] <= CTR_MIN;
      else if (upd_i && (idx_i == IDX_W'(g)))
        cnt_q[g] <= ctr_next(cnt_q[g], taken_i);
    end
  end

  assign cnt_o = cnt_q[idx_i];
endmodule

// File: rtl/corr_dir_pred.sv
module corr_dir_pred
  import cdp_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int HIST_BITS    = 5,
  parameter int PC_BITS      = 5,
  parameter int LO_ZERO_BITS = 2,
  localparam int IDX_W       = HIST_BITS + PC_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              taken_i,
  output logic              mispredict_valid_o,
  output logic              mispredict_o
);
  logic [HIST_BITS-1:0] hist_q;
  logic [IDX_W-1:0]     idx;
  ctr_t                 rd_cnt;
  logic                 pred_taken;
  logic                 mv_q, mp_q;

  cdp_index #(
    .ADDR_W(ADDR_W), .HIST_BITS(HIST_BITS),
    .PC_BITS(PC_BITS), .LO_ZERO_BITS(LO_ZERO_BITS)
  ) index_i (
    .addr_i(addr_i), .hist_i(hist_q), .idx_o(idx)
  );

  cdp_history #(.HIST_BITS(HIST_BITS)) history_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(valid_i),
    .bit_i(taken_i), .hist_o(hist_q)
  );

  cdp_ctr_table #(.IDX_W(IDX_W)) table_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx), .upd_i(valid_i),
    .taken_i(taken_i), .cnt_o(rd_cnt)
  );

  assign pred_taken = rd_cnt[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mv_q <= 1'b0;
      mp_q <= 1'b0;
    end else begin
      mv_q <= valid_i;
      mp_q <= valid_i & (pred_taken ^ taken_i);
    end
  end

  assign mispredict_valid_o = mv_q;
  assign mispredict_o       = mp_q;
endmodule

// File: rtl/corr_dir_pred_chk.sv
module corr_dir_pred_chk #(
  parameter int HIST_BITS = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 taken_i,
  input logic [HIST_BITS-1:0] hist_q,
  input logic [1:0]           rd_cnt,
  input logic                 mispredict_valid_o,
  input logic                 mispredict_o
);
  AST_OUT_FOLLOWS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> mispredict_valid_o); // R6

  AST_OUT_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !mispredict_valid_o); // R6

  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mispredict_valid_o |-> !mispredict_o); // R6

  AST_FLAG_VS_COUNTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (mispredict_o == (($past(rd_cnt) >= 2'd2) != $past(taken_i)))); // R3

  AST_HIST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (hist_q[0] == $past(taken_i))); // R5

  AST_HIST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hist_q)); // R8
endmodule

bind corr_dir_pred corr_dir_pred_chk #(.HIST_BITS(HIST_BITS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .taken_i(taken_i),
  .hist_q(hist_q), .rd_cnt(rd_cnt),
  .mispredict_valid_o(mispredict_valid_o), .mispredict_o(mispredict_o)
);

// File: tb/corr_dir_pred_tb_top.sv
module corr_dir_pred_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic        taken;
    logic        misp;
  } vec_t;

  // defaults: LO_ZERO_BITS=2, PC_BITS=5, HIST_BITS=5
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h04, 1'b1, 1'b1},  // R1 fresh counter predicts not-taken
    '{32'h04, 1'b1, 1'b1},  // R5 history shifts, new index
    '{32'h04, 1'b1, 1'b1},
    '{32'h04, 1'b1, 1'b1},
    '{32'h04, 1'b1, 1'b1},  // history now all ones
    '{32'h04, 1'b1, 1'b1},  // R7 ctr 0->1
    '{32'h04, 1'b1, 1'b1},  // R7 ctr 1->2
    '{32'h04, 1'b1, 1'b0},  // R3 ctr 2 predicts taken, 2->3
    '{32'h84, 1'b1, 1'b0},  // R2 alias above field, R4 stays 3
    '{32'h07, 1'b1, 1'b0},  // R2 alignment bits ignored
    '{32'h08, 1'b1, 1'b1},  // R2 other field, fresh counter
    '{32'h04, 1'b0, 1'b1},  // R9 pre-update ctr 3 predicts taken
    '{32'h04, 1'b0, 1'b0},  // new history, fresh counter
    '{32'h08, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        taken_i = 1'b0;
  logic        mispredict_valid_o;
  logic        mispredict_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  corr_dir_pred dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .addr_i(addr_i),
    .taken_i(taken_i), .mispredict_valid_o(mispredict_valid_o),
    .mispredict_o(mispredict_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ev(input logic [31:0] a, input logic t, input logic m, input string req);
    addr_i  = a;
    taken_i = t;
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(mispredict_valid_o, 1'b1, {req, " valid"});
    chk(mispredict_o, m, req);
  endtask

  task automatic idle(input logic [31:0] a, input logic t, input string req);
    addr_i  = a;
    taken_i = t;
    valid_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(mispredict_valid_o, 1'b0, {req, " idle valid"});
    chk(mispredict_o, 1'b0, {req, " idle flag"});
  endtask

  task automatic do_reset();
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mispredict_valid_o, 1'b0, "R1 reset valid");
    chk(mispredict_o, 1'b0, "R1 reset flag");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mispredict_valid_o, 1'b0, "R1 reset valid");
    chk(mispredict_o, 1'b0, "R1 reset flag");

    // vector table, back-to-back events
    for (int i = 0; i < NV; i++)
      ev(VECS[i].addr, VECS[i].taken, VECS[i].misp, $sformatf("R6 vec %0d", i));
    idle(32'h0, 1'b0, "R6");

    // R4 floor: not-taken at zero stays zero
    do_reset();
    ev(32'h10, 1'b0, 1'b0, "R4 floor a");
    ev(32'h10, 1'b0, 1'b0, "R4 floor b");
    ev(32'h10, 1'b0, 1'b0, "R4 floor c");
    ev(32'h10, 1'b1, 1'b1, "R4 floor no wrap");
    idle(32'h10, 1'b1, "R4");

    // R8 idle cycles with junk inputs keep state
    do_reset();
    for (int i = 0; i < 5; i++) ev(32'h18, 1'b1, 1'b1, "R5 fill history");
    ev(32'h18, 1'b1, 1'b1, "R7 ctr 0->1");
    ev(32'h18, 1'b1, 1'b1, "R7 ctr 1->2");
    idle(32'h18, 1'b0, "R8");
    idle(32'h18, 1'b0, "R8");
    idle(32'h58, 1'b0, "R8");
    ev(32'h18, 1'b1, 1'b0, "R8 state kept over idle");

    // R1 reset mid-run clears history and counters
    idle(32'h18, 1'b0, "R1");
    do_reset();
    ev(32'h18, 1'b1, 1'b1, "R1 mid-run reset");
    idle(32'h0, 1'b0, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule